// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a data cache of 1024 words of 32 bits, organised as 256 lines holding four words each, placed between a processor port and a word-wide memory port. Each memory block can live in exactly one line, picked by its block address modulo the line count. A lookup that finds the line valid with a matching tag is answered in the same cycle, with no stall.

On a miss the processor is stalled. If the victim line has been modified, all four of its words are first written to memory. The whole requested block is then fetched, one word per handshake beat. A write that hits changes only the cache and marks the line modified. A write that misses first fetches the line and then merges the new word into it.

The processor holds its request stable until it sees a cycle with `cpu_stall` low. The access completes at the clock edge that ends that cycle.

Top module: `dmc_cache`

## Requirements
- R1: The byte address splits as follows: bits [1:0] are ignored, bits [3:2] select the word in the line, bits [11:4] are the line index and bits [31:12] are the tag.
- R2: A request whose line is valid and whose stored tag equals the address tag raises `cpu_hit`, keeps `cpu_stall` low and presents the addressed word on `cpu_rdata` in the same cycle.
- R3: Two blocks with the same index and different tags cannot both be resident. Accessing one evicts the other, so the next access to the evicted block misses.
- R4: Reset marks every line invalid and not modified, so the first reference to any block misses. With no request pending, `cpu_stall` and `mem_req` are low.
- R5: A write hit updates only the cached word and marks the line modified. It causes no memory beat.
- R6: Evicting a modified line first writes all four of its words (write beats, `mem_we`=1) in word order 0..3, at address {old tag, index, word, 2'b00}. Evicting an unmodified line writes nothing.
- R7: A miss reads the four words of the block (read beats, `mem_we`=0) in word order 0..3, at address {tag, index, word, 2'b00}. After that, every word of the block hits.
- R8: When memory acknowledges each beat in the cycle it is requested, `cpu_stall` stays high for 5 cycles on a clean miss and 9 cycles on a dirty miss. The word is then delivered in the cycle where `cpu_stall` is low and `cpu_hit` is low.
- R9: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay stable until `mem_ack` is sampled high. Each acknowledged beat moves exactly one word.
- R10: A write miss fetches the line, then merges the write data into the addressed word and marks the line modified. A later read of the same word returns the written data.
- R11: Starting from an empty cache, the word reference string 0 1 2 3 4 3 4 15 gives 3 misses and 5 hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held until stall is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_hit | output | 1 | Lookup hit in the current cycle |
| cpu_rdata | output | 32 | Read data, valid when stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Beat byte address |
| mem_wdata | output | 32 | Write beat data |
| mem_rdata | input | 32 | Read beat data |
| mem_ack | input | 1 | Beat accepted or data returned |

## Verification
A hit is due in the cycle the request is applied. The bench samples `cpu_hit`, `cpu_stall` and `cpu_rdata` a quarter period after driving the request, away from any edge. On a miss the bench counts stalled cycles, sampling once per cycle at the same offset, and compares the count with 5 or 9 whenever the bench memory acknowledges every beat at once; it reads the delivered word in the first cycle where stall is low. Each memory beat is checked against its expected address, direction and data in the cycle it is acknowledged. The acknowledgement is driven on the falling edge, so the cache takes the beat at the next rising edge.

// File: rtl/dmc_pkg.sv
// Shared geometry and controller state encoding for the direct-mapped cache.
// Assumes a power-of-two line count and words per line.
package dmc_pkg;
    localparam int ADDR_W  = 32;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 2;
    localparam int OFFS_W  = 2;
    localparam int INDEX_W = 8;
    localparam int TAG_W   = ADDR_W - INDEX_W - OFFS_W - BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WBACK  = 2'd1,
        ST_REFILL = 2'd2,
        ST_RESP   = 2'd3
    } ctrl_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
// Per-line valid, modified and tag storage with one combinational read port
// and one update port, both addressed by the same line index.
// Assumes the update always writes valid=1 together with a tag and modified flag.
module dmc_tag_store #(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    output logic               line_valid,
    output logic               line_dirty,
    output logic [TAG_W-1:0]   line_tag,
    input  logic               upd_en,
    input  logic               upd_dirty,
    input  logic [TAG_W-1:0]   upd_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Status bits: cleared on reset, set by a line update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (upd_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= upd_dirty;
        end
    end

    // Tag array: written on update, never reset.
    always_ff @(posedge clk) begin
        if (upd_en) tag_q[idx] <= upd_tag;
    end

    // Lookup read of the addressed line.
    always_comb begin
        line_valid = valid_q[idx];
        line_dirty = dirty_q[idx];
        line_tag   = tag_q[idx];
    end

    // R4: reset leaves every line invalid and clean.
    assert_reset_invalid_R4: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0 && dirty_q == '0));

    // R5: a modified line is always a valid line.
    assert_dirty_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/dmc_data_store.sv
// Data array of LINES x WORDS words, one combinational read port and one
// synchronous write port, each addressed by {line index, word offset}.
module dmc_data_store #(
    parameter int INDEX_W = 8,
    parameter int OFFS_W  = 2,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic [INDEX_W-1:0] idx,
    input  logic [OFFS_W-1:0]  rd_off,
    output logic [DATA_W-1:0]  rd_word,
    input  logic               wr_en,
    input  logic [OFFS_W-1:0]  wr_off,
    input  logic [DATA_W-1:0]  wr_word
);
    localparam int DEPTH = 1 << (INDEX_W + OFFS_W);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Word write from a refill beat or a processor store.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[{idx, wr_off}] <= wr_word;
    end

    // Word read for the processor or a write-back beat.
    assign rd_word = mem_q[{idx, rd_off}];
endmodule

// File: rtl/dmc_ctrl.sv
// Miss controller: idle lookup, optional four-beat write-back, four-beat
// refill, then a single response cycle. The beat counter advances on mem_ack.
// Assumes the processor request stays stable while the controller is busy.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int OFFS_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              look_hit,
    input  logic              victim_dirty,
    input  logic              mem_ack,
    output ctrl_state_t       state,
    output logic [OFFS_W-1:0] beat,
    output logic              last_beat
);
    ctrl_state_t       state_q, state_d;
    logic [OFFS_W-1:0] beat_q, beat_d;

    assign last_beat = &beat_q;

    // Next-state and beat-count decision.
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        case (state_q)
            ST_IDLE: begin
                beat_d = '0;
                if (cpu_req && !look_hit)
                    state_d = victim_dirty ? ST_WBACK : ST_REFILL;
            end
            ST_WBACK: if (mem_ack) begin
                beat_d = beat_q + 1'b1;
                if (last_beat) state_d = ST_REFILL;
            end
            ST_REFILL: if (mem_ack) begin
                beat_d = beat_q + 1'b1;
                if (last_beat) state_d = ST_RESP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and beat registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    assign state = state_q;
    assign beat  = beat_q;

    // R6: a finished write-back always continues with the refill.
    assert_wback_then_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WBACK && mem_ack && last_beat) |=> (state_q == ST_REFILL && beat_q == '0));

    // R7: a finished refill always leads to the response cycle.
    assert_refill_then_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL && mem_ack && last_beat) |=> state_q == ST_RESP);

    // R9: without an acknowledge the beat does not advance.
    assert_beat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WBACK || state_q == ST_REFILL) && !mem_ack) |=> $stable(beat_q));
endmodule

// File: rtl/dmc_cache.sv
// Direct-mapped write-back, write-allocate cache with multiword lines.
// Splits the processor address into tag, index and word offset, answers hits
// combinationally, and drives a request/acknowledge memory port one word per beat.
// Assumes the processor holds cpu_req and its fields until cpu_stall is low.
module dmc_cache
    import dmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_hit,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int OFF_LO = BYTE_W;
    localparam int IDX_LO = BYTE_W + OFFS_W;
    localparam int TAG_LO = IDX_LO + INDEX_W;

    logic [TAG_W-1:0]   req_tag;
    logic [INDEX_W-1:0] req_idx;
    logic [OFFS_W-1:0]  req_off;
    logic               line_valid, line_dirty, look_hit;
    logic [TAG_W-1:0]   line_tag;
    ctrl_state_t        state;
    logic [OFFS_W-1:0]  beat;
    logic               last_beat;
    logic               in_idle, in_wback, in_refill, in_resp;
    logic               store_now, refill_beat;
    logic               data_wr, tag_upd;
    logic [OFFS_W-1:0]  rd_off, wr_off;
    logic [DATA_W-1:0]  wr_word, rd_word;

    // Address field split.
    always_comb begin
        req_tag = cpu_addr[ADDR_W-1:TAG_LO];
        req_idx = cpu_addr[TAG_LO-1:IDX_LO];
        req_off = cpu_addr[IDX_LO-1:OFF_LO];
    end

    dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) tags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (req_idx),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .upd_en     (tag_upd),
        .upd_dirty  (store_now),
        .upd_tag    (req_tag)
    );

    dmc_data_store #(.INDEX_W(INDEX_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) data_i (
        .clk     (clk),
        .idx     (req_idx),
        .rd_off  (rd_off),
        .rd_word (rd_word),
        .wr_en   (data_wr),
        .wr_off  (wr_off),
        .wr_word (wr_word)
    );

    dmc_ctrl #(.OFFS_W(OFFS_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .look_hit     (look_hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ack      (mem_ack),
        .state        (state),
        .beat         (beat),
        .last_beat    (last_beat)
    );

    // State decode and hit detection.
    always_comb begin
        in_idle   = (state == ST_IDLE);
        in_wback  = (state == ST_WBACK);
        in_refill = (state == ST_REFILL);
        in_resp   = (state == ST_RESP);
        look_hit  = line_valid && (line_tag == req_tag);
    end

    // Array write controls: processor store on hit or after allocation, refill beats.
    always_comb begin
        store_now   = cpu_req && cpu_we && ((in_idle && look_hit) || in_resp);
        refill_beat = in_refill && mem_ack;
        data_wr     = store_now || refill_beat;
        tag_upd     = store_now || (refill_beat && last_beat);
        wr_off      = in_refill ? beat : req_off;
        wr_word     = in_refill ? mem_rdata : cpu_wdata;
        rd_off      = in_wback ? beat : req_off;
    end

    // Processor-side responses.
    always_comb begin
        cpu_hit   = in_idle && cpu_req && look_hit;
        cpu_rdata = rd_word;
        cpu_stall = (in_idle && cpu_req && !look_hit) || in_wback || in_refill;
    end

    // Memory-side beat: victim address during write-back, request address during refill.
    always_comb begin
        mem_req   = in_wback || in_refill;
        mem_we    = in_wback;
        mem_addr  = {(in_wback ? line_tag : req_tag), req_idx, beat, {BYTE_W{1'b0}}};
        mem_wdata = rd_word;
    end

    // R9: beat fields hold until acknowledged.
    assert_beat_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R5: a write hit leaves the memory port idle in the following cycle.
    assert_write_hit_no_mem_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && cpu_we) |=> !mem_req);

    // R8: the cycle after a refill ends never stalls.
    assert_resp_no_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_refill && mem_ack && last_beat) |=> (!cpu_stall && !cpu_hit));
endmodule

// File: tb/dmc_cache_tb_top.sv
module dmc_cache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_hit, cpu_stall;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    dmc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0, fails = 0;
    logic [31:0] tbm  [MEM_WORDS];
    logic [31:0] gold [MEM_WORDS];
    logic        m_valid [256];
    logic        m_dirty [256];
    logic [19:0] m_tag   [256];
    logic [31:0] wb_base, rd_base;
    int          wr_n, rd_n, miss_n;
    logic        slow_mem = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_word(input int i);
        return (i * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    // Bench memory: decides the acknowledge on the falling edge and checks each beat.
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            bit ok;
            if (pend) chk(mem_addr == pend_addr, "R9 beat address held", mem_addr, pend_addr);
            ok = slow_mem ? ($urandom % 3 == 0) : 1'b1;
            mem_ack = ok;
            if (ok) begin
                if (mem_we) begin
                    chk(mem_addr == wb_base + 32'(wr_n * 4), "R6 write-back beat address", mem_addr, wb_base + 32'(wr_n * 4));
                    chk(mem_wdata == gold[mem_addr[13:2]], "R6 write-back data", mem_wdata, gold[mem_addr[13:2]]);
                    tbm[mem_addr[13:2]] = mem_wdata;
                    wr_n++;
                end else begin
                    chk(mem_addr == rd_base + 32'(rd_n * 4), "R7 refill beat address", mem_addr, rd_base + 32'(rd_n * 4));
                    mem_rdata = tbm[mem_addr[13:2]];
                    rd_n++;
                end
            end
            pend = !ok;
            pend_addr = mem_addr;
        end else begin
            mem_ack = 1'b0;
            pend = 1'b0;
        end
    end

    // One processor access with all expected results computed from the model.
    task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wdata);
        logic [7:0]  idx;
        logic [19:0] tg;
        logic [11:0] w;
        bit          e_hit, e_wb, g_hit;
        int          stalls;
        logic [31:0] got;
        idx = addr[11:4];
        tg  = addr[31:12];
        w   = addr[13:2];
        e_hit = m_valid[idx] && (m_tag[idx] == tg);
        e_wb  = !e_hit && m_valid[idx] && m_dirty[idx];
        wb_base = {m_tag[idx], idx, 4'b0};
        rd_base = {tg, idx, 4'b0};
        wr_n = 0;
        rd_n = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        #(CLK_PERIOD/4);
        g_hit = cpu_hit;
        stalls = 0;
        while (cpu_stall && stalls < 1000) begin
            stalls++;
            @(negedge clk);
            #(CLK_PERIOD/4);
        end
        got = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_req = 1'b0;
        if (!e_hit) miss_n++;
        chk(g_hit == e_hit, "R2 hit flag", 32'(g_hit), 32'(e_hit));
        if (!we) chk(got == gold[w], "R2/R7 read data", got, gold[w]);
        chk(wr_n == (e_wb ? 4 : 0), "R6 write-back beat count", 32'(wr_n), e_wb ? 32'd4 : 32'd0);
        chk(rd_n == (e_hit ? 0 : 4), "R7 refill beat count", 32'(rd_n), e_hit ? 32'd0 : 32'd4);
        if (!slow_mem)
            chk(stalls == (e_hit ? 0 : (e_wb ? 9 : 5)), "R8 stall cycles", 32'(stalls), e_hit ? 32'd0 : (e_wb ? 32'd9 : 32'd5));
        if (e_wb)
            for (int k = 0; k < 4; k++)
                chk(tbm[wb_base[13:2] + 12'(k)] == gold[wb_base[13:2] + 12'(k)], "R6 victim in memory",
                    tbm[wb_base[13:2] + 12'(k)], gold[wb_base[13:2] + 12'(k)]);
        if (we) gold[w] = wdata;
        m_valid[idx] = 1'b1;
        m_tag[idx]   = tg;
        m_dirty[idx] = we ? 1'b1 : (e_hit ? m_dirty[idx] : 1'b0);
    endtask

    function automatic logic [31:0] mk_addr(input int tg, input int idx, input int wo, input int by);
        return {18'b0, 2'(tg), 8'(idx), 2'(wo), 2'(by)};
    endfunction

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin
            tbm[i]  = seed_word(i);
            gold[i] = seed_word(i);
        end
        for (int i = 0; i < 256; i++) begin
            m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0;
        end
        miss_n = 0;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk(!cpu_stall && !mem_req, "R4 idle after reset", {30'b0, cpu_stall, mem_req}, 32'd0);

        // R11: reference string on an empty cache (R4 first reference misses)
        begin
            int refs [8] = '{0, 1, 2, 3, 4, 3, 4, 15};
            foreach (refs[i]) access(1'b0, 32'(refs[i] * 4), '0);
            chk(miss_n == 3, "R11 reference string misses", 32'(miss_n), 32'd3);
        end
        // R5: write hit, no beats; R1: byte offset ignored on read
        access(1'b1, mk_addr(0, 0, 1, 0), 32'hCAFE_0001);
        access(1'b0, mk_addr(0, 0, 1, 3), '0);
        // R3/R6: conflicting block evicts the dirty line
        access(1'b0, mk_addr(1, 0, 2, 0), '0);
        access(1'b0, mk_addr(0, 0, 1, 0), '0);
        // R10: write miss allocates, then the merged word and its neighbours hit
        access(1'b1, mk_addr(2, 5, 2, 0), 32'hBEEF_0010);
        access(1'b0, mk_addr(2, 5, 2, 0), '0);
        access(1'b0, mk_addr(2, 5, 0, 0), '0);
        // R10/R6: dirty write miss onto the same line
        access(1'b1, mk_addr(3, 5, 3, 1), 32'h1234_5678);
        access(1'b0, mk_addr(2, 5, 2, 0), '0);

        // Random mix over a few tags and indices, fast then slow memory (R1..R10)
        for (int n = 0; n < 1200; n++) begin
            slow_mem = (n >= 600);
            access($urandom % 2 == 1, mk_addr($urandom % 4, ($urandom % 4 == 0) ? $urandom % 256 : $urandom % 8,
                   $urandom % 4, $urandom % 4), $urandom);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule